// File: doc/BRIEF.md
# Dual-Lane Flash Command Snooper

This block sits between a transmit byte queue and one or two serial flash byte lanes. It moves bytes from the transmit queue onto the lanes and puts what the lanes return into a receive queue. While a flash command header is in flight, it sends the same byte to every active lane. Once the header is over, it gives each lane its own byte from the queue. The payload is then split across two flash devices wired side by side.

The block learns where the header ends by watching the first byte sent after chip select is asserted. It treats that byte as an opcode and loads the number of address, mode and dummy bytes that follow it. It counts those bytes down on each beat and then switches to striping. An unrecognised opcode keeps the block in broadcast mode until chip select drops.

A start pulse launches a run. The run continues until a byte is needed and the transmit queue is empty. Each lane transfer is a valid/ready byte handshake, and only one lane is served at a time. The serial shifters and both queues are outside the block.

Top module: `flash_lane_snooper`

## Requirements
- R1: After reset the block is idle: `busy_o`, `tx_pop_o`, `rx_push_o` and every `lane_valid_o` bit are low. The first byte sent after reset is decoded as an opcode.
- R2: The opcode byte itself is broadcast. The opcodes listed below are each followed by a fixed number of further broadcast beats, after which striping begins.
  - 8'h03, 8'h02, 8'hA2 and 8'h32 are followed by 3 further broadcast beats.
  - 8'h0B, 8'h3B, 8'h6B and 8'hBB are followed by 4.
  - 8'hEB is followed by 6.
- R3: Any other opcode value leaves the block broadcasting for every later beat until chip select is released.
- R4: In broadcast mode each beat pops one byte and sends it on lane 0 and then, when wide, on lane 1. Only the byte returned by lane 0 is pushed to the receive queue.
- R5: In striping mode each active lane pops its own byte, in lane order 0 then 1. Each lane's returned byte is pushed in that same order.
- R6: When a pop is needed and `tx_empty_i` is high, `underflow_o` pulses for one cycle and the run ends with `busy_o` low. This also applies to a pop needed halfway through a beat. A beat cut short this way does not advance the opcode countdown.
- R7: When a lane returns a byte that must be stored while `rx_full_i` is high, the byte is dropped (no push) and `overflow_o` pulses for one cycle.
- R8: While `cs_active_i` is low, the block returns to waiting for an opcode. While it stays high, the countdown carries over from one run to the next.
- R9: With `wide_i` low only lane 0 is used, and striping gives the same byte stream as broadcast.
- R10: At most one `lane_valid_o` bit is high at a time. A raised valid keeps its lane and its `lane_tx_o` byte until the cycle in which `lane_ready_i` of that lane is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when idle |
| wide_i | input | 1 | 1: both lanes active, 0: lane 0 only |
| cs_active_i | input | 1 | High while any chip select is asserted |
| tx_empty_i | input | 1 | Transmit queue empty |
| tx_data_i | input | BYTE_W | Head of transmit queue (first-word fall-through) |
| tx_pop_o | output | 1 | Removes the head of the transmit queue |
| rx_full_i | input | 1 | Receive queue full |
| rx_push_o | output | 1 | Writes `rx_data_o` into the receive queue |
| rx_data_o | output | BYTE_W | Byte returned by the lane being served |
| lane_valid_o | output | NUM_LANES | Per-lane byte request |
| lane_tx_o | output | BYTE_W | Byte to send on the requested lane |
| lane_ready_i | input | NUM_LANES | Per-lane completion of the byte transfer |
| lane_rx_i | input | NUM_LANES*BYTE_W | Byte returned by each lane, lane 0 in the low bits |
| underflow_o | output | 1 | One-cycle pulse: pop needed from an empty queue |
| overflow_o | output | 1 | One-cycle pulse: returned byte dropped |
| busy_o | output | 1 | A run is in progress |

## Verification
The hardest case to reach is the transmit queue running dry between lane 0 and lane 1 of a striped beat. Lane 0 has already transferred and stored its byte, while the countdown must stay where it is. The bench reaches it by loading an odd number of payload bytes after a known opcode. The second hard case is a countdown that continues across two separate runs. The bench splits an opcode's header over two start pulses while holding chip select, and compares the result against a fresh decode after chip select is released. Every one of the 256 opcode values is swept in wide mode against an arithmetic model of the lane and receive streams.

// File: rtl/flsnp_pkg.sv
package flsnp_pkg;

    typedef enum logic [1:0] {
        SNP_WAIT_OP = 2'd0,
        SNP_PLAIN   = 2'd1,
        SNP_COUNT   = 2'd2,
        SNP_STRIPE  = 2'd3
    } snp_mode_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_FETCH = 2'd1,
        RUN_XFER  = 2'd2
    } run_e;

endpackage

// File: rtl/flsnp_opdec.sv
module flsnp_opdec #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic [BYTE_W-1:0] op_i,
    output logic              hit_o,
    output logic [CNT_W-1:0]  cnt_o
);
    // Number of broadcast beats that follow each recognised opcode
    always_comb begin
        hit_o = 1'b1;
        cnt_o = '0;
        case (op_i)
            BYTE_W'(8'h03), BYTE_W'(8'h02),
            BYTE_W'(8'hA2), BYTE_W'(8'h32): cnt_o = CNT_W'(3);
            BYTE_W'(8'h0B), BYTE_W'(8'h3B),
            BYTE_W'(8'h6B), BYTE_W'(8'hBB): cnt_o = CNT_W'(4);
            BYTE_W'(8'hEB):                 cnt_o = CNT_W'(6);
            default:                        hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/flsnp_mode_track.sv
module flsnp_mode_track
    import flsnp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_active_i,
    input  logic              beat_done_i,
    input  logic [BYTE_W-1:0] beat_byte_i,
    output logic              stripe_o
);
    typedef struct packed {
        snp_mode_e        mode;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t             trk_d, trk_q;
    logic             op_hit;
    logic [CNT_W-1:0] op_cnt;

    flsnp_opdec #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_opdec (
        .op_i  (beat_byte_i),
        .hit_o (op_hit),
        .cnt_o (op_cnt)
    );

    always_comb begin
        trk_d = trk_q;
        if (!cs_active_i) begin
            trk_d.mode = SNP_WAIT_OP;
            trk_d.cnt  = '0;
        end else if (beat_done_i) begin
            case (trk_q.mode)
                SNP_WAIT_OP: begin
                    if (op_hit) begin
                        trk_d.mode = SNP_COUNT;
                        trk_d.cnt  = op_cnt;
                    end else begin
                        trk_d.mode = SNP_PLAIN;
                    end
                end
                SNP_COUNT: begin
                    if (trk_q.cnt == CNT_W'(1)) begin
                        trk_d.mode = SNP_STRIPE;
                        trk_d.cnt  = '0;
                    end else begin
                        trk_d.cnt = trk_q.cnt - CNT_W'(1);
                    end
                end
                default: trk_d = trk_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '{mode: SNP_WAIT_OP, cnt: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign stripe_o = (trk_q.mode == SNP_STRIPE);
endmodule

// File: rtl/flsnp_lane_mux.sv
module flsnp_lane_mux #(
    parameter int NUM_LANES = 2,
    parameter int BYTE_W    = 8,
    parameter int LANE_W    = 1
) (
    input  logic [LANE_W-1:0]           sel_i,
    input  logic                        drive_i,
    input  logic [NUM_LANES-1:0]        ready_i,
    input  logic [NUM_LANES*BYTE_W-1:0] rx_i,
    output logic [NUM_LANES-1:0]        valid_o,
    output logic                        sel_ready_o,
    output logic [BYTE_W-1:0]           sel_rx_o
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign valid_o[g] = drive_i && (sel_i == LANE_W'(g));
    end

    assign sel_ready_o = |(valid_o & ready_i);

    always_comb begin
        sel_rx_o = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (sel_i == LANE_W'(i)) begin
                sel_rx_o = rx_i[i*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/flash_lane_snooper.sv
module flash_lane_snooper
    import flsnp_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int BYTE_W    = 8,
    parameter int CNT_W     = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        start_i,
    input  logic                        wide_i,
    input  logic                        cs_active_i,
    input  logic                        tx_empty_i,
    input  logic [BYTE_W-1:0]           tx_data_i,
    output logic                        tx_pop_o,
    input  logic                        rx_full_i,
    output logic                        rx_push_o,
    output logic [BYTE_W-1:0]           rx_data_o,
    output logic [NUM_LANES-1:0]        lane_valid_o,
    output logic [BYTE_W-1:0]           lane_tx_o,
    input  logic [NUM_LANES-1:0]        lane_ready_i,
    input  logic [NUM_LANES*BYTE_W-1:0] lane_rx_i,
    output logic                        underflow_o,
    output logic                        overflow_o,
    output logic                        busy_o
);
    localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

    typedef struct packed {
        run_e              run;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] cur;
    } seq_t;

    seq_t seq_d, seq_q;
    logic stripe;
    logic beat_done;
    logic need_pop;
    logic last_lane;
    logic sel_ready;

    flsnp_mode_track #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_track (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_active_i (cs_active_i),
        .beat_done_i (beat_done),
        .beat_byte_i (seq_q.cur),
        .stripe_o    (stripe)
    );

    flsnp_lane_mux #(.NUM_LANES(NUM_LANES), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_mux (
        .sel_i       (seq_q.lane),
        .drive_i     (seq_q.run == RUN_XFER),
        .ready_i     (lane_ready_i),
        .rx_i        (lane_rx_i),
        .valid_o     (lane_valid_o),
        .sel_ready_o (sel_ready),
        .sel_rx_o    (rx_data_o)
    );

    // Lane 0 always owns a fresh byte; other lanes only while striping
    assign need_pop  = (seq_q.lane == '0) || stripe;
    assign last_lane = wide_i ? (seq_q.lane == LAST_LANE) : 1'b1;

    always_comb begin
        seq_d       = seq_q;
        tx_pop_o    = 1'b0;
        rx_push_o   = 1'b0;
        underflow_o = 1'b0;
        overflow_o  = 1'b0;
        beat_done   = 1'b0;
        case (seq_q.run)
            RUN_IDLE: begin
                if (start_i) begin
                    seq_d.run  = RUN_FETCH;
                    seq_d.lane = '0;
                end
            end
            RUN_FETCH: begin
                if (!need_pop) begin
                    seq_d.run = RUN_XFER;
                end else if (tx_empty_i) begin
                    underflow_o = 1'b1;
                    seq_d.run   = RUN_IDLE;
                    seq_d.lane  = '0;
                end else begin
                    tx_pop_o  = 1'b1;
                    seq_d.cur = tx_data_i;
                    seq_d.run = RUN_XFER;
                end
            end
            RUN_XFER: begin
                if (sel_ready) begin
                    if (need_pop) begin
                        if (rx_full_i) begin
                            overflow_o = 1'b1;
                        end else begin
                            rx_push_o = 1'b1;
                        end
                    end
                    seq_d.run = RUN_FETCH;
                    if (last_lane) begin
                        beat_done  = 1'b1;
                        seq_d.lane = '0;
                    end else begin
                        seq_d.lane = seq_q.lane + LANE_W'(1);
                    end
                end
            end
            default: seq_d.run = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{run: RUN_IDLE, lane: '0, cur: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lane_tx_o = seq_q.cur;
    assign busy_o    = (seq_q.run != RUN_IDLE);
endmodule

// File: rtl/flsnp_checker.sv
module flsnp_checker #(
    parameter int NUM_LANES = 2,
    parameter int BYTE_W    = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wide_i,
    input logic                 tx_empty_i,
    input logic                 tx_pop_o,
    input logic                 rx_full_i,
    input logic                 rx_push_o,
    input logic [NUM_LANES-1:0] lane_valid_o,
    input logic [BYTE_W-1:0]    lane_tx_o,
    input logic [NUM_LANES-1:0] lane_ready_i,
    input logic                 underflow_o,
    input logic                 overflow_o,
    input logic                 busy_o
);
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!tx_pop_o && lane_valid_o == '0 && !rx_push_o));

    p_push_from_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_push_o |-> ((lane_valid_o & lane_ready_i) != '0));

    p_pop_has_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pop_o |-> !tx_empty_i);

    p_underflow_ends_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underflow_o |=> !busy_o);

    p_underflow_on_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underflow_o |-> tx_empty_i);

    p_no_overflow_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (rx_full_i && !rx_push_o));

    p_no_push_when_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_push_o |-> !rx_full_i);

    p_narrow_lane0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wide_i |-> ((lane_valid_o >> 1) == '0));

    p_one_lane_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lane_valid_o));

    p_hold_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lane_valid_o != '0 && (lane_valid_o & lane_ready_i) == '0)
        |=> ($stable(lane_valid_o) && $stable(lane_tx_o)));
endmodule

bind flash_lane_snooper flsnp_checker #(
    .NUM_LANES (NUM_LANES),
    .BYTE_W    (BYTE_W)
) u_flsnp_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wide_i       (wide_i),
    .tx_empty_i   (tx_empty_i),
    .tx_pop_o     (tx_pop_o),
    .rx_full_i    (rx_full_i),
    .rx_push_o    (rx_push_o),
    .lane_valid_o (lane_valid_o),
    .lane_tx_o    (lane_tx_o),
    .lane_ready_i (lane_ready_i),
    .underflow_o  (underflow_o),
    .overflow_o   (overflow_o),
    .busy_o       (busy_o)
);

// File: tb/flash_lane_snooper_tb_top.sv
`timescale 1ns/1ps
module flash_lane_snooper_tb_top;
    typedef logic [7:0] u8_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wide = 1'b1;
    logic       cs_act = 1'b1;
    logic       tx_empty;
    u8_t        tx_data;
    logic       tx_pop;
    logic       rx_full;
    logic       rx_push;
    u8_t        rx_data;
    logic [1:0] lane_valid;
    u8_t        lane_tx;
    logic [1:0] lane_ready = 2'b00;
    logic [15:0] lane_rx;
    logic       uf, of, busy;

    always #4 clk = ~clk;

    flash_lane_snooper #(.NUM_LANES(2), .BYTE_W(8), .CNT_W(3)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide),
        .cs_active_i(cs_act), .tx_empty_i(tx_empty), .tx_data_i(tx_data),
        .tx_pop_o(tx_pop), .rx_full_i(rx_full), .rx_push_o(rx_push),
        .rx_data_o(rx_data), .lane_valid_o(lane_valid), .lane_tx_o(lane_tx),
        .lane_ready_i(lane_ready), .lane_rx_i(lane_rx), .underflow_o(uf),
        .overflow_o(of), .busy_o(busy)
    );

    // Queue and lane models
    u8_t tx_mem [0:8191];
    int  tx_rd = 0, tx_wr = 0;
    int  rx_cnt = 0, rx_base = 0, rx_cap = 1000;
    assign tx_empty = (tx_rd >= tx_wr);
    assign tx_data  = tx_mem[tx_rd % 8192];
    assign rx_full  = ((rx_cnt - rx_base) >= rx_cap);
    assign lane_rx  = {lane_tx ^ 8'h22, lane_tx ^ 8'h11};

    u8_t lg0[$], lg1[$], rxl[$];
    u8_t e0[$], e1[$], er[$];
    int  uf_cnt = 0, of_cnt = 0, r10_bad = 0;
    logic pop_s = 1'b0, push_s = 1'b0, hold_pend = 1'b0;
    logic [1:0] rdy_nxt = 2'b00, hv = 2'b00;
    u8_t ht = 8'h00;

    always @(negedge clk) begin
        if (lane_valid[0] && lane_ready[0]) lg0.push_back(lane_tx);
        if (lane_valid[1] && lane_ready[1]) lg1.push_back(lane_tx);
        if (rx_push) rxl.push_back(rx_data);
        if (uf) uf_cnt++;
        if (of) of_cnt++;
        if ($countones(lane_valid) > 1) r10_bad++;
        if (hold_pend && (lane_valid != hv || lane_tx != ht)) r10_bad++;
        hold_pend = (lane_valid != 2'b00) && ((lane_valid & lane_ready) == 2'b00);
        hv = lane_valid;
        ht = lane_tx;
        pop_s = tx_pop;
        push_s = rx_push;
        for (int i = 0; i < 2; i++) rdy_nxt[i] = lane_valid[i] && !lane_ready[i];
    end

    always @(posedge clk) begin
        if (pop_s) tx_rd <= tx_rd + 1;
        if (push_s) rx_cnt <= rx_cnt + 1;
        lane_ready <= rdy_nxt;
    end

    // Bench bookkeeping and reference model
    int  tests = 0, fails = 0;
    bit  done = 1'b0;
    u8_t tvec [0:31];
    int  m_mode = 0;   // 0 wait opcode, 1 plain, 2 counting, 3 striping
    int  m_cnt = 0;
    int  exp_of = 0;

    function automatic int op_len(input u8_t op);
        case (op)
            8'h03, 8'h02, 8'hA2, 8'h32: return 3;
            8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
            8'hEB:                      return 6;
            default:                    return 0;
        endcase
    endfunction

    task automatic model(input int n, input bit w, input int cap);
        int  idx = 0;
        int  fill = 0;
        u8_t cur = 8'h00;
        bit  stop = 1'b0;
        exp_of = 0;
        while (!stop) begin
            for (int l = 0; l < (w ? 2 : 1); l++) begin
                bit popn = (l == 0) || (m_mode == 3);
                if (!stop) begin
                    if (popn) begin
                        if (idx == n) begin
                            stop = 1'b1;
                        end else begin
                            cur = tvec[idx];
                            idx++;
                        end
                    end
                    if (!stop) begin
                        if (l == 0) e0.push_back(cur); else e1.push_back(cur);
                        if (popn) begin
                            if (fill < cap) begin
                                er.push_back(cur ^ ((l == 0) ? 8'h11 : 8'h22));
                                fill++;
                            end else begin
                                exp_of++;
                            end
                        end
                    end
                end
            end
            if (!stop) begin
                if (m_mode == 0) begin
                    m_cnt  = op_len(cur);
                    m_mode = (m_cnt == 0) ? 1 : 2;
                end else if (m_mode == 2) begin
                    m_cnt--;
                    if (m_cnt == 0) m_mode = 3;
                end
            end
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_q(input u8_t a[$], input u8_t e[$], input string tag, input string what);
        int bad = -1;
        tests++;
        if (a.size() == e.size()) begin
            for (int k = 0; k < a.size(); k++) if (bad < 0 && a[k] != e[k]) bad = k;
        end
        if (a.size() != e.size()) begin
            fails++;
            $display("FAIL %s %s: actual %0d bytes expected %0d bytes", tag, what, a.size(), e.size());
        end else if (bad >= 0) begin
            fails++;
            $display("FAIL %s %s[%0d]: actual %02h expected %02h", tag, what, bad, a[bad], e[bad]);
        end
    endtask

    task automatic drop_cs();
        @(negedge clk) cs_act = 1'b0;
        @(negedge clk);
        @(negedge clk) cs_act = 1'b1;
        m_mode = 0;
        m_cnt  = 0;
    endtask

    task automatic run_case(input int n, input bit w, input int cap, input string tag);
        @(negedge clk);
        lg0.delete(); lg1.delete(); rxl.delete();
        e0.delete(); e1.delete(); er.delete();
        uf_cnt = 0; of_cnt = 0;
        wide = w; rx_cap = cap; rx_base = rx_cnt;
        for (int k = 0; k < n; k++) tx_mem[(tx_wr + k) % 8192] = tvec[k];
        tx_wr = tx_wr + n;
        model(n, w, cap);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check_q(lg0, e0, tag, "lane0 bytes");
        check_q(lg1, e1, tag, "lane1 bytes");
        check_q(rxl, er, tag, "rx pushes");
        check_int(uf_cnt, 1, tag, "underflow pulses");
        check_int(of_cnt, exp_of, tag, "overflow pulses");
    endtask

    task automatic fill_vec(input u8_t op, input int seed);
        tvec[0] = op;
        for (int k = 1; k < 32; k++) tvec[k] = u8_t'(seed * 7 + k * 29 + 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_int(busy, 0, "R1", "busy after reset");
        check_int(lane_valid, 0, "R1", "lane valid after reset");
        check_int(tx_pop, 0, "R1", "pop after reset");
        check_int(rx_push, 0, "R1", "push after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_int(busy, 0, "R1", "busy after release");

        // R1 R2: first byte after reset is an opcode
        fill_vec(8'h6B, 1);
        run_case(12, 1'b1, 1000, "R1 R2 R5");

        // R6: start with an empty queue
        drop_cs();
        run_case(0, 1'b1, 1000, "R6 empty start");

        // R2 R3 R4 R5: all opcode values, wide
        for (int op = 0; op < 256; op++) begin
            drop_cs();
            fill_vec(u8_t'(op), op);
            if (op_len(u8_t'(op)) != 0) run_case(10, 1'b1, 1000, "R2 R4 R5 sweep");
            else                        run_case(10, 1'b1, 1000, "R3 R4 sweep");
        end

        // R9: narrow mode
        for (int op = 0; op < 256; op += 23) begin
            drop_cs();
            fill_vec(u8_t'(op), op + 5);
            run_case(9, 1'b0, 1000, "R9 narrow");
        end
        drop_cs();
        fill_vec(8'hEB, 3);
        run_case(12, 1'b0, 1000, "R9 narrow striping");

        // R6 R5: queue runs dry between lane 0 and lane 1
        drop_cs();
        fill_vec(8'h02, 9);
        run_case(7, 1'b1, 1000, "R6 R5 mid-beat");
        // countdown not advanced: continue striping without cs drop
        fill_vec(8'h55, 4);
        run_case(4, 1'b1, 1000, "R6 R8 resume");

        // R8: header split across two runs
        drop_cs();
        fill_vec(8'h0B, 2);
        run_case(3, 1'b1, 1000, "R8 split a");
        for (int k = 0; k < 8; k++) tvec[k] = u8_t'(8'h40 + k);
        run_case(8, 1'b1, 1000, "R8 split b");
        drop_cs();
        fill_vec(8'hEB, 6);
        run_case(11, 1'b1, 1000, "R8 fresh decode");

        // R7: receive queue fills
        drop_cs();
        fill_vec(8'h03, 11);
        run_case(10, 1'b1, 3, "R7 overflow");
        drop_cs();
        fill_vec(8'h77, 12);
        run_case(6, 1'b1, 0, "R7 full from start");

        // R10: handshake discipline across the whole run
        check_int(r10_bad, 0, "R10", "valid or byte changed before ready");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R6 watchdog: actual run still busy, expected idle");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule